// File: doc/BRIEF.md
# Burst Clock Gating Controller

The block turns each rising edge of a slow, asynchronous reference clock into a short burst of clock periods for downstream logic, and holds its clock output parked high at all other times. A fast free-running source clock drives all of its logic. The reference edge is brought into the source domain by a small synchronizer with an asynchronous clear. The edge event restarts a period counter, and a comparator ends the burst once the programmed number of periods has elapsed.

The burst period comes from a programmable divider on the source clock. Each half-period lasts a programmed number of source cycles. Together with the programmable period count, this lets the user trade switching activity against settling noise. The output acts like a NAND gate between an enable and an internal oscillation. While enabled it is low during the first half of every period and high during the second half. While disabled it is forced high. A busy flag covers the whole burst.

Top module: `burst_clk_gate`

## Requirements
- R1: While reset is asserted, and after it is released with no reference edge, `busy` is 0 and `emb_clk` is 1.
- R2: A rising edge on `ref_clk` that the source clock samples at edge E0 sets `busy` to 1 at source edge E2. `emb_clk` drops to 0 at that same edge, so every burst starts with its low half.
- R3: Each half-period of `emb_clk` inside a burst lasts exactly D source cycles, where D is `cfg_div`. A `cfg_div` of 0 acts as D = 1.
- R4: A burst holds exactly M full periods (low half, then high half), where M is `cfg_cycles`. `busy` stays 1 for 2·D·M source cycles and falls only after the final high half has ended.
- R5: Between bursts, `emb_clk` is held at 1.
- R6: A reference edge seen while `cfg_cycles` is 0 starts no burst.
- R7: A new reference edge during a burst restarts it. Two source cycles after the new edge is sampled, the output begins a fresh low half and the period count starts again from zero.
- R8: `cfg_cycles` and `cfg_div` are captured when a burst starts. Changing them during the burst does not alter that burst.
- R9: Only rising edges of `ref_clk` count. A reference held high, or a falling edge, starts no further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Asynchronous reference clock; each rising edge requests a burst |
| cfg_cycles | input | CNT_W | Number of periods per burst |
| cfg_div | input | DIV_W | Source cycles per half-period (0 treated as 1) |
| emb_clk | output | 1 | Gated burst clock, idle high |
| busy | output | 1 | High for the whole burst |

## Verification
The assertions assume that `ref_clk` stays stable for at least two source cycles around each edge, so that the synchronizer produces exactly one edge pulse per rising edge. They also assume that any setting they read is stable during the cycle in which a burst starts. The stimulus changes `ref_clk` and the settings only on falling edges of the source clock. It holds each reference level for at least two source cycles, and it changes settings only before an edge is raised or after the burst has started. This keeps every edge and capture unambiguous for the cycle-exact comparison.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Map a programmed divide value onto an effective half-period length (0 acts as 1).
  function automatic logic [15:0] eff_div16(input logic [15:0] raw);
    return (raw == 16'd0) ? 16'd1 : raw;
  endfunction
endpackage

// File: rtl/bcg_ref_sync.sv
module bcg_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/bcg_half_timer.sv
module bcg_half_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             half_end
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign half_end = run && !restart && (cnt_q == half_len - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = '0;
    else if (half_end) cnt_d = '0;
    else if (run)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcg_cycle_ctr.sv
module bcg_cycle_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             period_end,
  input  logic [CNT_W-1:0] limit,
  output logic             active
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             act_q, act_d;
  logic [EXT_W-1:0] cyc_next;

  assign cyc_next = {1'b0, cyc_q} + 1'b1;

  always_comb begin
    cyc_d = cyc_q;
    act_d = act_q;
    if (restart) begin
      cyc_d = '0;
      act_d = 1'b1;
    end else if (act_q && period_end) begin
      if (cyc_next == {1'b0, limit}) begin
        cyc_d = '0;
        act_d = 1'b0;
      end else begin
        cyc_d = cyc_next[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      act_q <= 1'b0;
    end else begin
      cyc_q <= cyc_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/burst_clk_gate.sv
module burst_clk_gate #(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic [CNT_W-1:0] cfg_cycles,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             emb_clk,
  output logic             busy
);
  import bcg_pkg::*;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic             edge_pulse;
  logic             start_go;
  logic [CNT_W-1:0] cyc_lim_q;
  logic [DIV_W-1:0] div_q, div_eff;
  logic [15:0]      div_wide;
  logic             osc_q, osc_d;
  logic             half_end;
  logic             period_end;

  // Reset asserts asynchronously, releases on the source clock.
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  bcg_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_src),
    .rst_n      (rst_n_int),
    .async_in   (ref_clk),
    .rise_pulse (edge_pulse)
  );

  assign start_go = edge_pulse && (cfg_cycles != '0);
  assign div_wide = eff_div16(16'(cfg_div));
  assign div_eff  = div_wide[DIV_W-1:0];

  // Settings captured at burst start only.
  always_ff @(posedge clk_src or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cyc_lim_q <= '0;
      div_q     <= '0;
    end else if (start_go) begin
      cyc_lim_q <= cfg_cycles;
      div_q     <= div_eff;
    end
  end

  bcg_half_timer #(.DIV_W(DIV_W)) u_half (
    .clk      (clk_src),
    .rst_n    (rst_n_int),
    .restart  (start_go),
    .run      (busy),
    .half_len (div_q),
    .half_end (half_end)
  );

  assign period_end = half_end && !osc_q;

  always_comb begin
    osc_d = osc_q;
    if (start_go)      osc_d = 1'b1;
    else if (half_end) osc_d = ~osc_q;
  end

  always_ff @(posedge clk_src or negedge rst_n_int) begin
    if (!rst_n_int) osc_q <= 1'b0;
    else            osc_q <= osc_d;
  end

  bcg_cycle_ctr #(.CNT_W(CNT_W)) u_cyc (
    .clk        (clk_src),
    .rst_n      (rst_n_int),
    .restart    (start_go),
    .period_end (period_end),
    .limit      (cyc_lim_q),
    .active     (busy)
  );

  // NAND gating: low phase while oscillation is high and burst enabled.
  assign emb_clk = ~(busy & osc_q);
endmodule

// File: rtl/burst_clk_gate_chk.sv
module burst_clk_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             edge_pulse,
  input logic [CNT_W-1:0] cfg_cycles,
  input logic             emb_clk,
  input logic             busy
);
  a_r5_idle_high: assert property (@(posedge clk_src) disable iff (!rst_n)
    !busy |-> emb_clk);

  a_r2_start_low: assert property (@(posedge clk_src) disable iff (!rst_n)
    (edge_pulse && cfg_cycles != '0) |=> (busy && !emb_clk));

  a_r6_zero_no_burst: assert property (@(posedge clk_src) disable iff (!rst_n)
    (edge_pulse && cfg_cycles == '0 && !busy) |=> !busy);

  a_r4_end_after_high: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(busy) |-> $past(emb_clk));

  a_r2_rise_needs_edge: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(busy) |-> $past(edge_pulse));
endmodule

bind burst_clk_gate burst_clk_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_src    (clk_src),
  .rst_n      (rst_n),
  .edge_pulse (edge_pulse),
  .cfg_cycles (cfg_cycles),
  .emb_clk    (emb_clk),
  .busy       (busy)
);

// File: tb/burst_clk_gate_test.sv
module burst_clk_gate_test;
  logic       clk_src = 1'b0;
  logic       rst_n;
  logic       ref_clk;
  logic [7:0] cfg_cycles;
  logic [3:0] cfg_div;
  logic       emb_clk;
  logic       busy;

  always #5 clk_src = ~clk_src;

  burst_clk_gate uut (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .ref_clk    (ref_clk),
    .cfg_cycles (cfg_cycles),
    .cfg_div    (cfg_div),
    .emb_clk    (emb_clk),
    .busy       (busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state.
  bit pending = 0;
  int pend    = 0;
  bit active  = 0;
  int age     = 0;
  int em      = 0;
  int en      = 1;

  task automatic cmp(input string tag, input string sig, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic eb, ee;
    @(negedge clk_src);
    if (pending) begin
      pend++;
      if (pend == 3) begin
        pending = 0;
        if (cfg_cycles != 0) begin
          active = 1;
          age    = 0;
          em     = cfg_cycles;
          en     = (cfg_div == 0) ? 1 : cfg_div;
        end
      end
    end
    eb = active && (age < 2 * en * em);
    if (active && !eb) active = 0;
    ee = eb ? (((age / en) % 2) == 1) : 1'b1;
    cmp(tag, "busy", busy, eb);
    cmp(tag, "emb_clk", emb_clk, ee);
    age++;
  endtask

  task automatic raise();
    ref_clk = 1'b1;
    pending = 1;
    pend    = 0;
  endtask

  task automatic burst(input string tag, input int m, input int n);
    int d;
    d = (n == 0) ? 1 : n;
    cfg_cycles = 8'(m);
    cfg_div    = 4'(n);
    raise();
    step(tag);
    step(tag);
    ref_clk = 1'b0;
    repeat (2 * d * m + 4) step(tag);
  endtask

  initial begin
    rst_n      = 1'b0;
    ref_clk    = 1'b0;
    cfg_cycles = 8'd0;
    cfg_div    = 4'd0;
    repeat (3) begin
      @(negedge clk_src);
      cmp("R1", "busy", busy, 1'b0);
      cmp("R1", "emb_clk", emb_clk, 1'b1);
    end
    rst_n = 1'b1;
    repeat (4) step("R1 idle after reset");

    // Sweep of burst length and divider: R2 R3 R4 R5, R6 for m=0.
    for (int m = 0; m <= 4; m++) begin
      for (int n = 0; n <= 3; n++) begin
        burst((m == 0) ? "R6 zero length" : "R2/R3/R4/R5 sweep", m, n);
      end
    end

    // R7: restart in the middle of a burst.
    cfg_cycles = 8'd3;
    cfg_div    = 4'd2;
    raise();
    step("R7"); step("R7");
    ref_clk = 1'b0;
    repeat (5) step("R7");
    raise();
    step("R7"); step("R7");
    ref_clk = 1'b0;
    repeat (20) step("R7 restarted burst");

    // R8: settings changed after start are ignored until next burst.
    cfg_cycles = 8'd2;
    cfg_div    = 4'd2;
    raise();
    step("R8"); step("R8");
    ref_clk = 1'b0;
    step("R8");
    step("R8");
    cfg_cycles = 8'd7;
    cfg_div    = 4'd1;
    repeat (12) step("R8 captured settings");
    burst("R8 new settings apply", 7, 1);

    // R9: reference held high gives one burst only; falling edge gives none.
    cfg_cycles = 8'd1;
    cfg_div    = 4'd1;
    raise();
    repeat (15) step("R9 held high");
    ref_clk = 1'b0;
    repeat (8) step("R9 falling edge");

    // R1: reset in the middle of a burst returns to the idle state.
    cfg_cycles = 8'd4;
    cfg_div    = 4'd3;
    raise();
    step("R1"); step("R1");
    ref_clk = 1'b0;
    repeat (4) step("R1");
    rst_n   = 1'b0;
    pending = 0;
    active  = 0;
    #1;
    cmp("R1 mid-burst reset", "busy", busy, 1'b0);
    cmp("R1 mid-burst reset", "emb_clk", emb_clk, 1'b1);
    @(negedge clk_src);
    rst_n = 1'b1;
    repeat (4) step("R1 after reset");
    burst("R2/R4 after reset", 2, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule